// File: doc/BRIEF.md
# Configurable Radix-2 Single-Delay-Feedback FFT Stage

This block is one pipeline stage of a radix-2 decimation-in-time FFT whose length can be changed at run time and which can carry several interleaved streams. Complex 16-bit samples arrive one per accepted transfer. A feedback delay line holds the upper butterfly operands until their partners arrive. A twiddle table rotates the lower operand through a three-multiplier complex product, and a butterfly forms the halved sum and difference. The sum leaves the stage at once. The difference goes back into the delay line and leaves during the next fill half-block.

The stage index is the parameter `STAGE`. The active transform length is the `len_mode` pin. The half-block select `in_sel` comes from an external control counter and travels with each sample. Within a stage, the twiddle sequence does not depend on length or stream count, so interleaved streams reuse the same coefficients. Input and output use valid/ready. A sample is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. A stalled output holds its data and valid until `out_ready` rises. Nothing in the stage changes in a cycle without an accepted sample. `len_mode` is configuration: it is changed only under reset.

Top module: `sdf_fft_stage`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1 and the output data are zero.
- R2: `in_ready` equals `!out_valid || out_ready`. Each accepted sample produces exactly one output, valid on the following cycle. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_re` and `out_im` stay unchanged.
- R3: With `in_sel`=0 (fill half), the output is the oldest entry of the delay line and the input sample is pushed into it.
- R4: With `in_sel`=1 (butterfly half), the delay-line head h and the rotated input t = x·W give output floor((h+t)/2) per component. The value floor((h−t)/2) is pushed into the delay line.
- R5: The delay depth is D = 2048 >> (STAGE + m), where `len_mode` 00 selects m=0 (2048 points), 01 selects m=1 (1024), and 10 or 11 select m=2 (512). D must be at least 1.
- R6: Twiddle index k starts at 0 after reset and advances by one on every accepted `in_sel`=1 sample, wrapping after 2^(STAGE−1)−1. W(k) = round(32767·cos(2πk/2^STAGE)) + j·round(−32767·sin(2πk/2^STAGE)), with rounding half away from zero.
- R7: Each component of x·W is computed exactly, then reduced as (p + 2^14) >> 15 (arithmetic shift) and saturated to [−32768, 32767].
- R8: In cycles without an accepted sample, the delay line, the twiddle counter and the output hold. The output stream after gaps equals the stream without gaps.
- R9: The delay line resets to zero, so the first D fill-half outputs after reset are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| len_mode | input | 2 | Transform length: 00=2048, 01=1024, 10/11=512 |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Stage can accept a sample |
| in_sel | input | 1 | Half-block select: 0 fill, 1 butterfly |
| in_re | input | 16 | Input real part, two's complement |
| in_im | input | 16 | Input imaginary part, two's complement |
| out_valid | output | 1 | Output sample present |
| out_ready | input | 1 | Consumer accepts output |
| out_re | output | 16 | Output real part |
| out_im | output | 16 | Output imaginary part |

## Verification
The bench builds the stage with STAGE=3. This gives delay depths of 256, 128 and 64 across the length modes, and a four-entry twiddle table that wraps many times per run. The 45-degree coefficient at index 1 lets full-scale corner inputs drive the rotated product into both saturation rails. Random output back-pressure and input gaps in the 1024-point run check stall holding and freeze behaviour against a reference queue model of the delay line.

// File: rtl/sdf_stage_pkg.sv
package sdf_stage_pkg;
  localparam int DW   = 16;
  localparam int FRAC = DW - 1;
  localparam int PW   = 2 * DW + 2;
  localparam int RW   = PW + 1;

  typedef struct packed {
    logic signed [DW-1:0] re;
    logic signed [DW-1:0] im;
  } cplx_t;

  // Round a Q(2*FRAC) product back to Q(FRAC) and clamp to the sample range.
  function automatic logic signed [DW-1:0] q_round_sat(input logic signed [RW-1:0] p);
    logic signed [RW-1:0] half;
    logic signed [RW-1:0] r;
    logic signed [RW-1:0] hi;
    logic signed [RW-1:0] lo;
    half = '0;
    half[FRAC-1] = 1'b1;
    hi = {{(RW-DW+1){1'b0}}, {(DW-1){1'b1}}};
    lo = ~hi;
    r = (p + half) >>> FRAC;
    if (r > hi) return hi[DW-1:0];
    if (r < lo) return lo[DW-1:0];
    return r[DW-1:0];
  endfunction
endpackage

// File: rtl/sdf_delay_line.sv
module sdf_delay_line
  import sdf_stage_pkg::*;
#(
  parameter int MAXD = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       shift,
  input  logic [1:0] mode,
  input  cplx_t      din,
  output cplx_t      dout
);
  localparam int T0 = MAXD - 1;
  localparam int T1 = (MAXD >= 2) ? MAXD / 2 - 1 : 0;
  localparam int T2 = (MAXD >= 4) ? MAXD / 4 - 1 : 0;

  logic signed [DW-1:0] sr_re [MAXD];
  logic signed [DW-1:0] sr_im [MAXD];

  for (genvar i = 0; i < MAXD; i++) begin : g_cell
    if (i == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sr_re[0] <= '0;
          sr_im[0] <= '0;
        end else if (shift) begin
          sr_re[0] <= din.re;
          sr_im[0] <= din.im;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sr_re[i] <= '0;
          sr_im[i] <= '0;
        end else if (shift) begin
          sr_re[i] <= sr_re[i-1];
          sr_im[i] <= sr_im[i-1];
        end
      end
    end
  end

  logic [1:0] eff_shift;
  assign eff_shift = (mode == 2'b11) ? 2'd2 : mode;

  always_comb begin
    case (eff_shift)
      2'd0:    dout = '{re: sr_re[T0], im: sr_im[T0]};
      2'd1:    dout = '{re: sr_re[T1], im: sr_im[T1]};
      default: dout = '{re: sr_re[T2], im: sr_im[T2]};
    endcase
  end

  // R5: the selected length must leave at least one word of delay
  assert_depth_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (MAXD >> eff_shift) != 0);

  // R8: no accepted sample, no movement in the line
  assert_line_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !shift |=> ($stable(sr_re[0]) && $stable(sr_im[0])));
endmodule

// File: rtl/sdf_twiddle_rom.sv
module sdf_twiddle_rom
  import sdf_stage_pkg::*;
#(
  parameter int STAGE = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  adv,
  output cplx_t w
);
  localparam int TW = 1 << (STAGE - 1);
  localparam int AW = (TW > 1) ? $clog2(TW) : 1;

  cplx_t          tbl [TW];
  logic [AW-1:0]  addr;
  logic [AW-1:0]  addr_nxt;
  cplx_t          q;

  for (genvar k = 0; k < TW; k++) begin : g_tw
    localparam real ANG = 6.283185307179586 * k / (2.0 ** STAGE);
    localparam real CR  = 32767.0 * $cos(ANG);
    localparam real SR  = -32767.0 * $sin(ANG);
    localparam int  CI  = (CR >= 0.0) ? $rtoi(CR + 0.5) : $rtoi(CR - 0.5);
    localparam int  SI  = (SR >= 0.0) ? $rtoi(SR + 0.5) : $rtoi(SR - 0.5);
    assign tbl[k] = '{re: DW'(CI), im: DW'(SI)};
  end

  assign addr_nxt = (addr == AW'(TW - 1)) ? '0 : addr + 1'b1;

  // Single read port with enable; data is the register itself.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
      q    <= tbl[0];
    end else if (adv) begin
      addr <= addr_nxt;
      q    <= tbl[addr_nxt];
    end
  end

  assign w = q;

  // R6: index wraps to zero after the last entry
  assert_tw_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && addr == AW'(TW - 1)) |=> (addr == '0));

  // R8: coefficient and index frozen without a butterfly sample
  assert_tw_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> ($stable(addr) && $stable(q)));
endmodule

// File: rtl/sdf_cmul3.sv
module sdf_cmul3
  import sdf_stage_pkg::*;
(
  input  cplx_t x,
  input  cplx_t w,
  output cplx_t y
);
  logic signed [DW:0]   s_ab;
  logic signed [DW:0]   d_dc;
  logic signed [DW:0]   s_cd;
  logic signed [DW:0]   a_e;
  logic signed [DW:0]   b_e;
  logic signed [DW:0]   c_e;
  logic signed [PW-1:0] m1;
  logic signed [PW-1:0] m2;
  logic signed [PW-1:0] m3;
  logic signed [RW-1:0] p_re;
  logic signed [RW-1:0] p_im;

  always_comb begin
    a_e  = (DW+1)'(x.re);
    b_e  = (DW+1)'(x.im);
    c_e  = (DW+1)'(w.re);
    s_ab = a_e + b_e;
    d_dc = (DW+1)'(w.im) - c_e;
    s_cd = c_e + (DW+1)'(w.im);
    m1   = s_ab * c_e;
    m2   = a_e * d_dc;
    m3   = b_e * s_cd;
    p_re = RW'(m1) - RW'(m3);
    p_im = RW'(m1) + RW'(m2);
    y.re = q_round_sat(p_re);
    y.im = q_round_sat(p_im);
  end
endmodule

// File: rtl/sdf_butterfly.sv
module sdf_butterfly
  import sdf_stage_pkg::*;
(
  input  cplx_t h,
  input  cplx_t t,
  output cplx_t sum_h,
  output cplx_t dif_h
);
  logic signed [DW:0] sr;
  logic signed [DW:0] si;
  logic signed [DW:0] dr;
  logic signed [DW:0] di;

  always_comb begin
    sr = (DW+1)'(h.re) + (DW+1)'(t.re);
    si = (DW+1)'(h.im) + (DW+1)'(t.im);
    dr = (DW+1)'(h.re) - (DW+1)'(t.re);
    di = (DW+1)'(h.im) - (DW+1)'(t.im);
    sum_h = '{re: sr[DW:1], im: si[DW:1]};
    dif_h = '{re: dr[DW:1], im: di[DW:1]};
  end
endmodule

// File: rtl/sdf_fft_stage.sv
module sdf_fft_stage
  import sdf_stage_pkg::*;
#(
  parameter int STAGE    = 4,
  parameter int FULL_LEN = 2048
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           len_mode,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic                 in_sel,
  input  logic signed [DW-1:0] in_re,
  input  logic signed [DW-1:0] in_im,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [DW-1:0] out_re,
  output logic signed [DW-1:0] out_im
);
  localparam int MAXD = FULL_LEN >> STAGE;

  cplx_t x;
  cplx_t head;
  cplx_t w;
  cplx_t t;
  cplx_t bsum;
  cplx_t bdif;
  cplx_t push;
  cplx_t nxt;
  cplx_t oreg;
  logic  fire;

  assign x        = '{re: in_re, im: in_im};
  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  sdf_delay_line #(.MAXD(MAXD)) u_line (
    .clk(clk), .rst_n(rst_n), .shift(fire), .mode(len_mode),
    .din(push), .dout(head)
  );

  sdf_twiddle_rom #(.STAGE(STAGE)) u_rom (
    .clk(clk), .rst_n(rst_n), .adv(fire && in_sel), .w(w)
  );

  sdf_cmul3 u_mul (.x(x), .w(w), .y(t));

  sdf_butterfly u_bf (.h(head), .t(t), .sum_h(bsum), .dif_h(bdif));

  assign push = in_sel ? bdif : x;
  assign nxt  = in_sel ? bsum : head;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      oreg      <= '0;
    end else begin
      if (fire) begin
        out_valid <= 1'b1;
        oreg      <= nxt;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  assign out_re = oreg.re;
  assign out_im = oreg.im;

  // R2: an accepted sample shows up on the next cycle
  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid);

  // R2: a blocked output holds
  assert_stall_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_re) && $stable(out_im)));

  // R8: drained with no new sample leaves the output empty
  assert_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && out_ready) |=> !out_valid);
endmodule

// File: tb/sdf_fft_stage_tb.sv
`timescale 1ns/1ps
module sdf_fft_stage_tb_top;
  localparam int STG = 3;
  localparam int TWN = 1 << (STG - 1);
  localparam int MXD = 2048 >> STG;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] len_mode = 2'b00;
  logic in_valid = 1'b0;
  logic in_ready;
  logic in_sel = 1'b0;
  logic signed [15:0] in_re = '0;
  logic signed [15:0] in_im = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic signed [15:0] out_re;
  logic signed [15:0] out_im;

  always #2.5 clk = ~clk;

  sdf_fft_stage #(.STAGE(STG)) dut_i (
    .clk(clk), .rst_n(rst_n), .len_mode(len_mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_sel(in_sel),
    .in_re(in_re), .in_im(in_im),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_re(out_re), .out_im(out_im)
  );

  int checks = 0;
  int failures = 0;

  // reference state
  int line_re[$];
  int line_im[$];
  int tw_k;
  int n_in;
  int cur_d;
  string cur_tag;
  bit ready_rand = 0;

  // scoreboard
  int sb_re[$];
  int sb_im[$];
  string sb_tag[$];

  function automatic int rnd(real v);
    return (v >= 0.0) ? $rtoi(v + 0.5) : $rtoi(v - 0.5);
  endfunction

  function automatic int rsat(longint p);
    longint r;
    r = (p + 64'sd16384) >>> 15;
    if (r > 32767) return 32767;
    if (r < -32768) return -32768;
    return int'(r);
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void model_reset();
    line_re.delete();
    line_im.delete();
    for (int i = 0; i < cur_d; i++) begin
      line_re.push_back(0);
      line_im.push_back(0);
    end
    tw_k = 0;
    n_in = 0;
  endfunction

  function automatic void model_step(int xr, int xi, bit sel);
    int hr, hi, er, ei, c, d, tr, ti;
    real ang;
    string tg;
    hr = line_re.pop_front();
    hi = line_im.pop_front();
    if (!sel) begin
      er = hr; ei = hi;
      line_re.push_back(xr);
      line_im.push_back(xi);
      tg = (n_in < cur_d) ? "R9" : "R3";
    end else begin
      ang = 6.283185307179586 * tw_k / (2.0 ** STG);
      c = rnd(32767.0 * $cos(ang));
      d = rnd(-32767.0 * $sin(ang));
      tw_k = (tw_k + 1) % TWN;
      tr = rsat(longint'(xr) * c - longint'(xi) * d);
      ti = rsat(longint'(xr) * d + longint'(xi) * c);
      er = (hr + tr) >>> 1;
      ei = (hi + ti) >>> 1;
      line_re.push_back((hr - tr) >>> 1);
      line_im.push_back((hi - ti) >>> 1);
      tg = cur_tag;
    end
    sb_re.push_back(er);
    sb_im.push_back(ei);
    sb_tag.push_back(tg);
  endfunction

  task automatic send(int xr, int xi);
    bit sel;
    sel = ((n_in / cur_d) % 2) == 1;
    @(negedge clk);
    in_valid = 1'b1;
    in_sel = sel;
    in_re = 16'(xr);
    in_im = 16'(xi);
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    model_step(xr, xi, sel);
    n_in++;
  endtask

  task automatic gap(int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic drain();
    ready_rand = 0;
    gap(6);
    check(sb_re.size() == 0, "R2 one output per accepted sample", sb_re.size(), 0);
  endtask

  task automatic do_reset(logic [1:0] m);
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    len_mode = m;
    cur_d = MXD >> ((m == 2'b11) ? 2 : m);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    #1;
    check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
    check(out_re == 0 && out_im == 0, "R1 output data after reset", out_re, 0);
  endtask

  // output consumer
  always @(negedge clk) begin
    out_ready <= ready_rand ? (($urandom % 3) != 0) : 1'b1;
  end

  // monitor
  bit prev_stall = 0;
  int prev_re, prev_im;
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (prev_stall)
        check(out_valid && out_re == prev_re && out_im == prev_im,
              "R2 stalled output holds", out_re, prev_re);
      if (out_valid && out_ready) begin
        if (sb_re.size() == 0) begin
          check(1'b0, "R2 unexpected output", out_re, 0);
        end else begin
          int er, ei;
          string tg;
          er = sb_re.pop_front();
          ei = sb_im.pop_front();
          tg = sb_tag.pop_front();
          check(out_re == er, {tg, " real part"}, out_re, er);
          check(out_im == ei, {tg, " imag part"}, out_im, ei);
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_re = out_re;
      prev_im = out_im;
    end else begin
      prev_stall = 0;
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(7));
    cur_d = MXD;
    // 2048-point mode: R3, R4, R6, R9
    do_reset(2'b00);
    for (int i = 0; i < 1024; i++) begin
      cur_tag = (i >= 512) ? "R6" : "R4";
      send(int'($urandom % 65536) - 32768, int'($urandom % 65536) - 32768);
    end
    drain();

    // 1024-point mode with back-pressure and input gaps: R2, R5, R8
    do_reset(2'b01);
    ready_rand = 1;
    for (int i = 0; i < 512; i++) begin
      cur_tag = (i >= 256) ? "R8" : "R5";
      if (i >= 256 && ($urandom % 4) == 0) gap(1 + $urandom % 3);
      send(int'($urandom % 65536) - 32768, int'($urandom % 65536) - 32768);
    end
    drain();

    // 512-point mode, full-scale inputs on the 45-degree coefficient: R7
    do_reset(2'b10);
    cur_tag = "R7";
    for (int i = 0; i < 256; i++) begin
      bit bf;
      bf = ((n_in / cur_d) % 2) == 1;
      if (bf && tw_k == 1)
        send(((i / 2) % 2 == 0) ? -32768 : 32767, ((i / 2) % 2 == 0) ? -32768 : 32767);
      else
        send(int'($urandom % 65536) - 32768, int'($urandom % 65536) - 32768);
    end
    drain();

    // code 11 also selects 512 points: R5
    do_reset(2'b11);
    cur_tag = "R5";
    for (int i = 0; i < 256; i++)
      send(int'($urandom % 65536) - 32768, int'($urandom % 65536) - 32768);
    drain();

    summary();
  end
endmodule